// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps a small direct-mapped store of cache lines coherent with other caches on a shared snooping bus. It uses a write-update discipline: when a processor writes a line that other caches also hold, the new word is broadcast on the bus and copied into every other holder, so no copy is ever invalidated. Each line is empty or in one of four states: exclusive-clean, shared-clean, shared-modified (the owner of a shared dirty block) and modified. A wired shared line reports whether any other cache holds the block. Writers use it to skip broadcasts when no other cache would receive them, and fills use it to decide between exclusive and shared.

The processor side presents one request at a time and holds it until a one-cycle done pulse. Misses and shared writes raise a bus request. When the grant arrives for one cycle, the controller drives a read, an update or a write-back flush in that same cycle and samples the shared line and fill data at the closing edge. At the same time the snoop side watches the other caches' commands. It asserts the shared line for blocks it holds, supplies dirty data when another cache reads, and takes in broadcast words.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line reads as empty (state code 0), no bus request is raised and no done pulse is given. State codes are 0 empty, 1 exclusive-clean, 2 shared-clean, 3 shared-modified, 4 modified. The low address bits select the line and the high bits form the tag.
- R2: A read miss issues a bus read (command code 1). The fill ends in shared-clean if the shared line is high at the grant, otherwise in exclusive-clean. The fill word comes from a holder's flush when one is given, otherwise from memory, and the read returns that word.
- R3: A write that hits an exclusive-clean or modified line completes with no bus command and leaves the line modified.
- R4: A write that hits a shared-clean or shared-modified line raises a bus request and leaves the local word and state untouched until granted. In the grant cycle it drives an update (code 2) carrying the new word. The line then ends shared-modified if the shared line was high, or modified if it was low.
- R5: A snooped update on a held block writes the broadcast word into the local copy, asserts the shared line, and turns shared-modified into shared-clean. Memory is not written by updates.
- R6: A snooped bus read on a held block asserts the shared line. A modified or shared-modified holder also drives its word as flush data and ends shared-modified. An exclusive-clean holder becomes shared-clean.
- R7: On a miss, a clean victim (exclusive-clean or shared-clean) is dropped with no bus command. A dirty victim is first written back with a flush command (code 3) carrying its own address and word, and only then is the read issued.
- R8: A write miss fills the line as in R2 and then completes as a write hit. It ends modified with a single bus command when no other copy exists, or shared-modified after a bus read and an update when one does.
- R9: No done pulse is given while a bus request is pending.
- R10: A bus command other than 0 appears only in a cycle in which the grant input is high.
- R11: When two controllers hold the same block, both copies are shared-clean or shared-modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_valid_i | input | 1 | Processor request, held until done |
| proc_we_i | input | 1 | 1 for write, 0 for read |
| proc_addr_i | input | ADDR_W | Request address |
| proc_wdata_i | input | DATA_W | Write word |
| proc_done_o | output | 1 | One-cycle completion pulse |
| proc_rdata_o | output | DATA_W | Read result, valid with done |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | One-cycle bus grant |
| bus_cmd_o | output | 2 | Issued command (0 none, 1 read, 2 update, 3 flush) |
| bus_addr_o | output | ADDR_W | Address of the issued command |
| bus_wdata_o | output | DATA_W | Word carried by update or flush |
| bus_rdata_i | input | DATA_W | Fill word for a bus read |
| shared_i | input | 1 | OR of the other caches' shared outputs |
| snoop_cmd_i | input | 2 | Command issued by another cache |
| snoop_addr_i | input | ADDR_W | Address of the snooped command |
| snoop_data_i | input | DATA_W | Word of the snooped command |
| shared_o | output | 1 | This cache holds the snooped block |
| flush_o | output | 1 | This cache supplies the snooped block |
| flush_data_o | output | DATA_W | Supplied word |
| line_state_o | output | LINES*3 | State code of each line |
| line_tag_o | output | LINES*TAG_W | Tag of each line |

## Verification
Two controllers share a modelled bus and memory. The main function is exercised with a single reader, a second reader joining, writes with and without a sharer, and the replacement of clean and dirty victims. The reader cases separate exclusive from shared fills and show whether flushed data is used instead of stale memory. Holding the grant back during a shared write shows whether the local copy is committed early. Two simultaneous writes to one shared block show whether both copies settle on the value and ownership of the write granted last.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

   localparam int ST_W = 3;

   typedef enum logic [2:0] {
      LS_INV   = 3'd0,
      LS_EXCL  = 3'd1,
      LS_SHCLN = 3'd2,
      LS_SHMOD = 3'd3,
      LS_MOD   = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_READ   = 2'd1,
      CMD_UPDATE = 2'd2,
      CMD_FLUSH  = 2'd3
   } bus_cmd_e;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_BUS  = 1'b1
   } ctrl_ph_e;

   function automatic logic is_dirty(line_st_e s);
      return (s == LS_SHMOD) || (s == LS_MOD);
   endfunction

endpackage

// File: rtl/upd_line_array.sv
module upd_line_array
   import upd_coh_pkg::*;
#(
   parameter int LINES  = 2,
   parameter int TAG_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(LINES)-1:0] rd_a_idx,
   output line_st_e                 rd_a_st,
   output logic [TAG_W-1:0]         rd_a_tag,
   output logic [DATA_W-1:0]        rd_a_data,
   input  logic [$clog2(LINES)-1:0] rd_b_idx,
   output line_st_e                 rd_b_st,
   output logic [TAG_W-1:0]         rd_b_tag,
   output logic [DATA_W-1:0]        rd_b_data,
   input  logic                     l_we,
   input  logic [$clog2(LINES)-1:0] l_idx,
   input  line_st_e                 l_st,
   input  logic [TAG_W-1:0]         l_tag,
   input  logic                     l_data_we,
   input  logic [DATA_W-1:0]        l_data,
   input  logic                     s_we,
   input  logic [$clog2(LINES)-1:0] s_idx,
   input  line_st_e                 s_st,
   input  logic                     s_data_we,
   input  logic [DATA_W-1:0]        s_data,
   output logic [LINES*ST_W-1:0]    st_flat_o,
   output logic [LINES*TAG_W-1:0]   tag_flat_o
);
   localparam int IDX_W = $clog2(LINES);

   logic [LINES*DATA_W-1:0] data_flat;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_e           st_q;
      logic [TAG_W-1:0]   tag_q;
      logic [DATA_W-1:0]  data_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= LS_INV;
            tag_q  <= '0;
            data_q <= '0;
         end else if (l_we && (l_idx == IDX_W'(g))) begin
            st_q  <= l_st;
            tag_q <= l_tag;
            if (l_data_we) data_q <= l_data;
         end else if (s_we && (s_idx == IDX_W'(g))) begin
            st_q <= s_st;
            if (s_data_we) data_q <= s_data;
         end
      end

      assign st_flat_o[g*ST_W +: ST_W]     = st_q;
      assign tag_flat_o[g*TAG_W +: TAG_W]  = tag_q;
      assign data_flat[g*DATA_W +: DATA_W] = data_q;
   end

   assign rd_a_st   = line_st_e'(st_flat_o[int'(rd_a_idx)*ST_W +: ST_W]);
   assign rd_a_tag  = tag_flat_o[int'(rd_a_idx)*TAG_W +: TAG_W];
   assign rd_a_data = data_flat[int'(rd_a_idx)*DATA_W +: DATA_W];
   assign rd_b_st   = line_st_e'(st_flat_o[int'(rd_b_idx)*ST_W +: ST_W]);
   assign rd_b_tag  = tag_flat_o[int'(rd_b_idx)*TAG_W +: TAG_W];
   assign rd_b_data = data_flat[int'(rd_b_idx)*DATA_W +: DATA_W];

endmodule

// File: rtl/upd_snoop_resp.sv
module upd_snoop_resp
   import upd_coh_pkg::*;
#(
   parameter int TAG_W  = 3,
   parameter int DATA_W = 8
) (
   input  bus_cmd_e             cmd,
   input  logic [TAG_W-1:0]     snp_tag,
   input  logic [DATA_W-1:0]    snp_data,
   input  line_st_e             st,
   input  logic [TAG_W-1:0]     tag,
   input  logic [DATA_W-1:0]    data,
   output logic                 shared_o,
   output logic                 flush_o,
   output logic [DATA_W-1:0]    flush_data_o,
   output logic                 upd_we,
   output line_st_e             upd_st,
   output logic                 upd_data_we,
   output logic [DATA_W-1:0]    upd_data
);
   logic holds;

   assign holds        = (st != LS_INV) && (tag == snp_tag);
   assign flush_data_o = data;
   assign upd_data     = snp_data;

   always_comb begin
      shared_o    = 1'b0;
      flush_o     = 1'b0;
      upd_we      = 1'b0;
      upd_st      = st;
      upd_data_we = 1'b0;
      if (holds) begin
         unique case (cmd)
            CMD_READ: begin
               shared_o = 1'b1;
               if (is_dirty(st)) begin
                  flush_o = 1'b1;
                  upd_we  = 1'b1;
                  upd_st  = LS_SHMOD;
               end else if (st == LS_EXCL) begin
                  upd_we = 1'b1;
                  upd_st = LS_SHCLN;
               end
            end
            CMD_UPDATE: begin
               shared_o    = 1'b1;
               upd_we      = 1'b1;
               upd_data_we = 1'b1;
               if (st == LS_SHMOD) upd_st = LS_SHCLN;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int LINES  = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          proc_valid_i,
   input  logic                          proc_we_i,
   input  logic [ADDR_W-1:0]             proc_addr_i,
   input  logic [DATA_W-1:0]             proc_wdata_i,
   output logic                          proc_done_o,
   output logic [DATA_W-1:0]             proc_rdata_o,
   output logic                          bus_req_o,
   input  logic                          bus_gnt_i,
   output logic [1:0]                    bus_cmd_o,
   output logic [ADDR_W-1:0]             bus_addr_o,
   output logic [DATA_W-1:0]             bus_wdata_o,
   input  logic [DATA_W-1:0]             bus_rdata_i,
   input  logic                          shared_i,
   input  logic [1:0]                    snoop_cmd_i,
   input  logic [ADDR_W-1:0]             snoop_addr_i,
   input  logic [DATA_W-1:0]             snoop_data_i,
   output logic                          shared_o,
   output logic                          flush_o,
   output logic [DATA_W-1:0]             flush_data_o,
   output logic [LINES*3-1:0]            line_state_o,
   output logic [LINES*(ADDR_W-$clog2(LINES))-1:0] line_tag_o
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end

   logic [IDX_W-1:0]  req_idx, snp_idx;
   logic [TAG_W-1:0]  req_tag, snp_tag;
   line_st_e          st_a, st_b, l_st, s_st;
   logic [TAG_W-1:0]  tag_a, tag_b, l_tag;
   logic [DATA_W-1:0] data_a, data_b, l_data, s_data;
   logic              l_we, l_data_we, s_we, s_data_we;
   bus_cmd_e          snp_cmd, op_q;
   ctrl_ph_e          ph_q;
   logic              done_q;
   logic [DATA_W-1:0] rdata_q;
   logic              hit, snoop_clash, accept, granted, fast_write;

   assign req_idx = proc_addr_i[IDX_W-1:0];
   assign req_tag = proc_addr_i[ADDR_W-1:IDX_W];
   assign snp_idx = snoop_addr_i[IDX_W-1:0];
   assign snp_tag = snoop_addr_i[ADDR_W-1:IDX_W];
   assign snp_cmd = bus_cmd_e'(snoop_cmd_i);

   upd_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_a_idx   (req_idx),
      .rd_a_st    (st_a),
      .rd_a_tag   (tag_a),
      .rd_a_data  (data_a),
      .rd_b_idx   (snp_idx),
      .rd_b_st    (st_b),
      .rd_b_tag   (tag_b),
      .rd_b_data  (data_b),
      .l_we       (l_we),
      .l_idx      (req_idx),
      .l_st       (l_st),
      .l_tag      (l_tag),
      .l_data_we  (l_data_we),
      .l_data     (l_data),
      .s_we       (s_we),
      .s_idx      (snp_idx),
      .s_st       (s_st),
      .s_data_we  (s_data_we),
      .s_data     (s_data),
      .st_flat_o  (line_state_o),
      .tag_flat_o (line_tag_o)
   );

   upd_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .cmd          (snp_cmd),
      .snp_tag      (snp_tag),
      .snp_data     (snoop_data_i),
      .st           (st_b),
      .tag          (tag_b),
      .data         (data_b),
      .shared_o     (shared_o),
      .flush_o      (flush_o),
      .flush_data_o (flush_data_o),
      .upd_we       (s_we),
      .upd_st       (s_st),
      .upd_data_we  (s_data_we),
      .upd_data     (s_data)
   );

   assign hit         = (st_a != LS_INV) && (tag_a == req_tag);
   assign snoop_clash = (snp_cmd != CMD_NONE) && (snp_idx == req_idx);
   assign accept      = (ph_q == PH_IDLE) && proc_valid_i && !done_q && !snoop_clash;
   assign granted     = (ph_q == PH_BUS) && bus_gnt_i;
   assign fast_write  = hit && proc_we_i && ((st_a == LS_EXCL) || (st_a == LS_MOD));

   always_comb begin
      l_we      = 1'b0;
      l_st      = st_a;
      l_tag     = tag_a;
      l_data    = proc_wdata_i;
      l_data_we = 1'b0;
      if (accept && fast_write) begin
         l_we      = 1'b1;
         l_st      = LS_MOD;
         l_data_we = 1'b1;
      end else if (granted) begin
         l_we = 1'b1;
         unique case (op_q)
            CMD_FLUSH:  l_st = LS_INV;
            CMD_READ: begin
               l_st      = shared_i ? LS_SHCLN : LS_EXCL;
               l_tag     = req_tag;
               l_data    = bus_rdata_i;
               l_data_we = 1'b1;
            end
            CMD_UPDATE: begin
               l_st      = shared_i ? LS_SHMOD : LS_MOD;
               l_data_we = 1'b1;
            end
            default: l_we = 1'b0;
         endcase
      end
   end

   assign bus_req_o    = (ph_q == PH_BUS);
   assign bus_cmd_o    = granted ? op_q : CMD_NONE;
   assign bus_addr_o   = (op_q == CMD_FLUSH) ? {tag_a, req_idx} : proc_addr_i;
   assign bus_wdata_o  = (op_q == CMD_FLUSH) ? data_a : proc_wdata_i;
   assign proc_done_o  = done_q;
   assign proc_rdata_o = rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         op_q    <= CMD_NONE;
         done_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            if (hit && !proc_we_i) begin
               done_q  <= 1'b1;
               rdata_q <= data_a;
            end else if (fast_write) begin
               done_q <= 1'b1;
            end else if (hit) begin
               ph_q <= PH_BUS;
               op_q <= CMD_UPDATE;
            end else begin
               ph_q <= PH_BUS;
               op_q <= is_dirty(st_a) ? CMD_FLUSH : CMD_READ;
            end
         end else if (granted) begin
            unique case (op_q)
               CMD_FLUSH:  op_q <= CMD_READ;
               CMD_READ:   ph_q <= PH_IDLE;
               CMD_UPDATE: begin
                  ph_q   <= PH_IDLE;
                  done_q <= 1'b1;
               end
               default:    ph_q <= PH_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/upd_coh_ctrl_chk.sv
module upd_coh_ctrl_chk #(
   parameter int LINES  = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_gnt_i,
   input logic               bus_req_o,
   input logic [1:0]         bus_cmd_o,
   input logic [ADDR_W-1:0]  bus_addr_o,
   input logic               shared_i,
   input logic               shared_o,
   input logic               flush_o,
   input logic               proc_done_o,
   input logic [LINES*3-1:0] line_state_o
);
   localparam int IDX_W = $clog2(LINES);

   function automatic logic [2:0] st_at(logic [LINES*3-1:0] v, logic [IDX_W-1:0] i);
      return v[int'(i)*3 +: 3];
   endfunction

   function automatic logic all_legal(logic [LINES*3-1:0] v);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < LINES; i++) if (v[i*3 +: 3] > 3'd4) ok = 1'b0;
      return ok;
   endfunction

   p_state_codes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      all_legal(line_state_o));

   p_fill_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o == 2'd1) |=>
      (st_at(line_state_o, $past(bus_addr_o[IDX_W-1:0])) == ($past(shared_i) ? 3'd2 : 3'd1)));

   p_upd_before_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o == 2'd2) |->
      ((st_at(line_state_o, bus_addr_o[IDX_W-1:0]) == 3'd2) ||
       (st_at(line_state_o, bus_addr_o[IDX_W-1:0]) == 3'd3)));

   p_upd_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o == 2'd2) |=>
      (st_at(line_state_o, $past(bus_addr_o[IDX_W-1:0])) == ($past(shared_i) ? 3'd3 : 3'd4)));

   p_flush_implies_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> shared_o);

   p_no_done_while_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o |-> !proc_done_o);

   p_cmd_needs_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o != 2'd0) |-> (bus_gnt_i && bus_req_o));

endmodule

bind upd_coh_ctrl upd_coh_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_gnt_i    (bus_gnt_i),
   .bus_req_o    (bus_req_o),
   .bus_cmd_o    (bus_cmd_o),
   .bus_addr_o   (bus_addr_o),
   .shared_i     (shared_i),
   .shared_o     (shared_o),
   .flush_o      (flush_o),
   .proc_done_o  (proc_done_o),
   .line_state_o (line_state_o)
);

// File: tb/upd_coh_ctrl_bench.sv
`timescale 1ns/1ps
module upd_coh_ctrl_bench;
   localparam int LINES = 2, ADDR_W = 4, DATA_W = 8, TAG_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0, errors = 0;
   logic [7:0] mem [16];

   logic a_valid = 0, a_we = 0, b_valid = 0, b_we = 0;
   logic [3:0] a_addr = 0, b_addr = 0;
   logic [7:0] a_wd = 0, b_wd = 0;
   logic a_done, b_done, a_req, b_req, a_sh, b_sh, a_fl, b_fl;
   logic [7:0] a_rd, b_rd, a_bw, b_bw, a_fd, b_fd, a_fill, b_fill;
   logic [1:0] a_cmd, b_cmd;
   logic [3:0] a_ba, b_ba;
   logic [5:0] a_st, b_st, a_tg, b_tg;
   logic gnt_a = 0, gnt_b = 0, hold_gnt = 0, last_b = 0;
   int a_ncmd = 0, b_ncmd = 0, a_nfl = 0, b_nfl = 0, ungranted = 0;

   assign a_fill = b_fl ? b_fd : mem[a_ba];
   assign b_fill = a_fl ? a_fd : mem[b_ba];

   upd_coh_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_upd_coh_ctrl (
      .clk(clk), .rst_n(rst_n), .proc_valid_i(a_valid), .proc_we_i(a_we),
      .proc_addr_i(a_addr), .proc_wdata_i(a_wd), .proc_done_o(a_done), .proc_rdata_o(a_rd),
      .bus_req_o(a_req), .bus_gnt_i(gnt_a), .bus_cmd_o(a_cmd), .bus_addr_o(a_ba),
      .bus_wdata_o(a_bw), .bus_rdata_i(a_fill), .shared_i(b_sh), .snoop_cmd_i(b_cmd),
      .snoop_addr_i(b_ba), .snoop_data_i(b_bw), .shared_o(a_sh), .flush_o(a_fl),
      .flush_data_o(a_fd), .line_state_o(a_st), .line_tag_o(a_tg));

   upd_coh_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_upd_coh_ctrl_b (
      .clk(clk), .rst_n(rst_n), .proc_valid_i(b_valid), .proc_we_i(b_we),
      .proc_addr_i(b_addr), .proc_wdata_i(b_wd), .proc_done_o(b_done), .proc_rdata_o(b_rd),
      .bus_req_o(b_req), .bus_gnt_i(gnt_b), .bus_cmd_o(b_cmd), .bus_addr_o(b_ba),
      .bus_wdata_o(b_bw), .bus_rdata_i(b_fill), .shared_i(a_sh), .snoop_cmd_i(a_cmd),
      .snoop_addr_i(a_ba), .snoop_data_i(a_bw), .shared_o(b_sh), .flush_o(b_fl),
      .flush_data_o(b_fd), .line_state_o(b_st), .line_tag_o(b_tg));

   // bus arbiter: one-cycle grants, alternating on contention
   always @(negedge clk) begin
      if (!rst_n) begin
         gnt_a = 0; gnt_b = 0;
      end else if (gnt_a || gnt_b) begin
         gnt_a = 0; gnt_b = 0;
      end else if (!hold_gnt) begin
         if (a_req && (!b_req || last_b)) begin gnt_a = 1; last_b = 0; end
         else if (b_req) begin gnt_b = 1; last_b = 1; end
      end
   end

   // memory: written only by flush commands (write-backs)
   always @(posedge clk) begin
      if (a_cmd == 2'd3) mem[a_ba] <= a_bw;
      if (b_cmd == 2'd3) mem[b_ba] <= b_bw;
      if (a_cmd != 0) a_ncmd++;
      if (b_cmd != 0) b_ncmd++;
      if (a_cmd == 2'd3) a_nfl++;
      if (b_cmd == 2'd3) b_nfl++;
      if ((a_cmd != 0 && !gnt_a) || (b_cmd != 0 && !gnt_b)) ungranted++;
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int sa(int i); return int'(a_st[i*3 +: 3]); endfunction
   function automatic int sb(int i); return int'(b_st[i*3 +: 3]); endfunction

   task automatic compat_r11();
      for (int i = 0; i < LINES; i++) begin
         int x = sa(i);
         int y = sb(i);
         if (x != 0 && y != 0 && a_tg[i*TAG_W +: TAG_W] == b_tg[i*TAG_W +: TAG_W])
            chk("R11 pair", int'((x == 2 || x == 3) && (y == 2 || y == 3)), 1);
      end
   endtask

   task automatic run_op(input bit who, input bit we, input logic [3:0] ad,
                         input logic [7:0] wd, output logic [7:0] rd);
      int n = 0;
      if (!who) begin a_valid = 1; a_we = we; a_addr = ad; a_wd = wd; end
      else      begin b_valid = 1; b_we = we; b_addr = ad; b_wd = wd; end
      do begin @(negedge clk); n++; end
      while (!(who ? b_done : a_done) && n < 400);
      if (n >= 400) chk("R9 op timeout", 0, 1);
      rd = who ? b_rd : a_rd;
      if (!who) a_valid = 0; else b_valid = 0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 state A", int'(a_st), 0);
      chk("R1 state B", int'(b_st), 0);
      chk("R1 req", int'(a_req | b_req), 0);
      chk("R1 done", int'(a_done | b_done), 0);
   endtask

   task automatic t_read_fills();
      logic [7:0] r;
      run_op(0, 0, 4'h2, 0, r);
      chk("R2 data alone", r, 8'h12);
      chk("R2 exclusive fill", sa(0), 1);
      run_op(1, 0, 4'h2, 0, r);
      chk("R2 data second", r, 8'h12);
      chk("R2 shared fill", sb(0), 2);
      chk("R6 exclusive to shared", sa(0), 2);
      compat_r11();
   endtask

   task automatic t_update_ordering();
      logic [7:0] r;
      int n = 0;
      hold_gnt = 1;
      a_valid = 1; a_we = 1; a_addr = 4'h2; a_wd = 8'hAA;
      repeat (5) @(negedge clk);
      chk("R9 no done while held", int'(a_done), 0);
      chk("R4 state held", sa(0), 2);
      run_op(1, 0, 4'h2, 0, r);
      chk("R4 peer sees old word", r, 8'h12);
      hold_gnt = 0;
      while (!a_done && n < 100) begin @(negedge clk); n++; end
      chk("R4 write completes", int'(a_done), 1);
      a_valid = 0;
      @(negedge clk);
      chk("R4 shared owner", sa(0), 3);
      chk("R5 peer stays clean", sb(0), 2);
      run_op(1, 0, 4'h2, 0, r);
      chk("R5 peer got word", r, 8'hAA);
      chk("R5 memory untouched", mem[2], 8'h12);
      run_op(1, 1, 4'h2, 8'hBB, r);
      chk("R5 owner demoted", sa(0), 2);
      chk("R4 new owner", sb(0), 3);
      run_op(0, 0, 4'h2, 0, r);
      chk("R5 word propagated", r, 8'hBB);
      compat_r11();
   endtask

   task automatic t_replacement();
      logic [7:0] r;
      int f0 = a_nfl;
      run_op(0, 0, 4'h4, 0, r);
      chk("R7 clean victim silent", a_nfl - f0, 0);
      chk("R7 memory kept", mem[2], 8'h12);
      chk("R2 new exclusive", sa(0), 1);
      chk("R2 new data", r, 8'h14);
      run_op(1, 1, 4'h2, 8'hCC, r);
      chk("R4 alone goes modified", sb(0), 4);
      f0 = b_nfl;
      run_op(1, 0, 4'h6, 0, r);
      chk("R7 dirty victim flushed", b_nfl - f0, 1);
      chk("R7 written back", mem[2], 8'hCC);
      chk("R7 refill", r, 8'h16);
      compat_r11();
   endtask

   task automatic t_exclusive_write();
      logic [7:0] r;
      int c0 = a_ncmd;
      run_op(0, 1, 4'h4, 8'h55, r);
      chk("R3 no bus command", a_ncmd - c0, 0);
      chk("R3 modified", sa(0), 4);
      run_op(1, 0, 4'h4, 0, r);
      chk("R6 flush data used", r, 8'h55);
      chk("R6 supplier owner", sa(0), 3);
      chk("R6 reader shared", sb(0), 2);
      chk("R6 memory not written", mem[4], 8'h14);
      compat_r11();
   endtask

   task automatic t_write_miss();
      logic [7:0] r;
      int c0 = a_ncmd;
      run_op(0, 1, 4'h3, 8'h77, r);
      chk("R8 alone modified", sa(1), 4);
      chk("R8 alone one command", a_ncmd - c0, 1);
      c0 = b_ncmd;
      run_op(1, 1, 4'h3, 8'h88, r);
      chk("R8 shared owner", sb(1), 3);
      chk("R8 read then update", b_ncmd - c0, 2);
      chk("R8 other demoted", sa(1), 2);
      run_op(0, 0, 4'h3, 0, r);
      chk("R8 other sees word", r, 8'h88);
      compat_r11();
   endtask

   task automatic t_race();
      logic [7:0] ra, rb;
      fork
         run_op(0, 1, 4'h4, 8'h01, ra);
         run_op(1, 1, 4'h4, 8'h02, rb);
      join
      run_op(0, 0, 4'h4, 0, ra);
      run_op(1, 0, 4'h4, 0, rb);
      chk("R5 copies agree", ra, rb);
      chk("R4 last writer owns", (ra == 8'h01) ? sa(0) : sb(0), 3);
      chk("R5 first writer clean", (ra == 8'h01) ? sb(0) : sa(0), 2);
      compat_r11();
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_read_fills();
      t_update_ordering();
      t_replacement();
      t_exclusive_write();
      t_write_miss();
      t_race();
      chk("R10 commands only when granted", ungranted, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule